// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two two's-complement operands of WIDTH bits (32 by default) and returns the full signed product of 2·WIDTH bits, split into a high word and a low word. It works one bit per clock. A single shift register holds three parts: an accumulator in the top half, the multiplier in the bottom half, and one extra bit below it. Each iteration looks at the lowest multiplier bit together with the bit that was shifted out before it. From that pair it adds the multiplicand to the accumulator, subtracts it, or leaves the accumulator alone. It then shifts the whole register one place to the right, copying the sign bit in from the left.

Because the recoding handles signed values directly, the operands need no conversion to magnitude form and the result needs no sign fix-up. A client pulses `start` with both operands while the block is idle. `busy` then stays high for exactly WIDTH cycles. `done` pulses for one cycle with the product on `prod_hi` and `prod_lo`, and the product stays there until the next accepted start.

Top module: `booth_seq_mult`

## Requirements
- R1: After reset, `busy`, `done`, `prod_hi` and `prod_lo` are all 0.
- R2: `start` is accepted at a rising clock edge where `busy` is 0. Both operands are captured at that edge, and `busy` is 1 from the next cycle onward.
- R3: An accepted operation performs exactly WIDTH iterations. `done` is 1 in the cycle that follows the WIDTH-th rising edge after the accepting edge, and `busy` is 0 in that cycle.
- R4: When `done` is 1, {`prod_hi`,`prod_lo`} equals the signed product of `mcand_i` and `mplier_i` as two's-complement numbers of 2·WIDTH bits, for operands of any sign.
- R5: With WIDTH=4, 2 × 7 gives `prod_hi`=4'b0000 and `prod_lo`=4'b1110, and 2 × (−3) gives `prod_hi`=4'b1111 and `prod_lo`=4'b1010.
- R6: Extreme operands give exact results. The accumulator path is WIDTH+1 bits wide, so (−2^(WIDTH−1)) × (−2^(WIDTH−1)) = 2^(2·WIDTH−2) and (−2^(WIDTH−1)) × (−1) = 2^(WIDTH−1).
- R7: `start` asserted while `busy` is 1 is ignored. It changes neither the result nor the completion cycle of the running operation, and it produces no extra `done`.
- R8: `done` is high for a single cycle. `prod_hi` and `prod_lo` keep their final value until the next accepted start.
- R9: `prod_hi` carries bits 2·WIDTH−1 down to WIDTH of the product, and `prod_lo` carries bits WIDTH−1 down to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a multiplication |
| mcand_i | input | WIDTH | Multiplicand, two's complement |
| mplier_i | input | WIDTH | Multiplier, two's complement |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: the product is valid |
| prod_hi | output | WIDTH | Upper word of the product |
| prod_lo | output | WIDTH | Lower word of the product |

## Verification
Every result is due WIDTH rising edges after the edge that accepted `start`. The driver reads the free-running cycle count just after that accepting edge and queues the due cycle with the expected product. The monitor samples on falling edges. When `done` appears it checks both the cycle number and the product, and any `done` that arrives with nothing queued counts as a failure.

The bench also checks the following:
- A stray `start` raised in the middle of an operation must not shift its completion cycle.
- A few cycles after completion, the held output must still match the last product.
- A second 4-bit instance is run on the two small reference cases.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef enum logic [1:0] {
    BOOTH_NOP = 2'd0,
    BOOTH_ADD = 2'd1,
    BOOTH_SUB = 2'd2
  } booth_op_e;

  // Bit pair (current multiplier LSB, bit shifted out before it)
  function automatic booth_op_e booth_recode(input logic cur, input logic prev);
    booth_op_e op;
    case ({cur, prev})
      2'b10:   op = BOOTH_SUB;   // a run of ones begins
      2'b01:   op = BOOTH_ADD;   // a run of ones has ended
      default: op = BOOTH_NOP;   // inside a run of zeros or of ones
    endcase
    return op;
  endfunction

endpackage

// File: rtl/booth_step_unit.sv
module booth_step_unit
  import booth_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] acc,
  input  logic [WIDTH-1:0] mq,
  input  logic             tail,
  input  logic [WIDTH-1:0] mcand,
  output logic [WIDTH-1:0] nxt_acc,
  output logic [WIDTH-1:0] nxt_mq,
  output logic             nxt_tail,
  output logic             op_add,
  output logic             op_sub
);

  localparam int XW = WIDTH + 1;

  booth_op_e        op;
  logic [XW-1:0]    acc_x;
  logic [XW-1:0]    mcand_x;
  logic [XW-1:0]    sum_x;

  always_comb begin
    op      = booth_recode(mq[0], tail);
    acc_x   = {acc[WIDTH-1], acc};
    mcand_x = {mcand[WIDTH-1], mcand};
    case (op)
      BOOTH_ADD: sum_x = acc_x + mcand_x;
      BOOTH_SUB: sum_x = acc_x - mcand_x;
      default:   sum_x = acc_x;
    endcase
  end

  // Arithmetic right shift of {sum, mq, tail}: sum fits WIDTH+1 bits, so its
  // top WIDTH bits already carry the correct sign.
  assign nxt_acc  = sum_x[XW-1:1];
  assign nxt_mq   = {sum_x[0], mq[WIDTH-1:1]};
  assign nxt_tail = mq[0];
  assign op_add   = (op == BOOTH_ADD);
  assign op_sub   = (op == BOOTH_SUB);

endmodule

// File: rtl/booth_iter_ctrl.sv
module booth_iter_ctrl #(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic load_en,
  output logic step_en,
  output logic last_step
);

  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

  logic [CW-1:0] remain;

  assign load_en   = start && !busy;
  assign step_en   = busy;
  assign last_step = busy && (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      remain <= '0;
    end else begin
      done <= last_step;
      if (load_en) begin
        busy   <= 1'b1;
        remain <= LAST_IDX;
      end else if (last_step) begin
        busy <= 1'b0;
      end else if (step_en) begin
        remain <= remain - 1'b1;
      end
    end
  end

endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplier_i,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] prod_hi,
  output logic [WIDTH-1:0] prod_lo
);

  logic             load_en;
  logic             step_en;
  logic             last_step;
  logic             op_add;
  logic             op_sub;
  logic [WIDTH-1:0] acc_q;
  logic [WIDTH-1:0] mq_q;
  logic             tail_q;
  logic [WIDTH-1:0] mcand_q;
  logic [WIDTH-1:0] acc_d;
  logic [WIDTH-1:0] mq_d;
  logic             tail_d;

  booth_iter_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .load_en  (load_en),
    .step_en  (step_en),
    .last_step(last_step)
  );

  booth_step_unit #(.WIDTH(WIDTH)) step_i (
    .acc     (acc_q),
    .mq      (mq_q),
    .tail    (tail_q),
    .mcand   (mcand_q),
    .nxt_acc (acc_d),
    .nxt_mq  (mq_d),
    .nxt_tail(tail_d),
    .op_add  (op_add),
    .op_sub  (op_sub)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      mq_q    <= '0;
      tail_q  <= 1'b0;
      mcand_q <= '0;
    end else if (load_en) begin
      acc_q   <= '0;
      mq_q    <= mplier_i;
      tail_q  <= 1'b0;
      mcand_q <= mcand_i;
    end else if (step_en) begin
      acc_q  <= acc_d;
      mq_q   <= mq_d;
      tail_q <= tail_d;
    end
  end

  assign prod_hi = acc_q;
  assign prod_lo = mq_q;

endmodule

// File: rtl/booth_seq_mult_chk.sv
module booth_seq_mult_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             op_add,
  input logic             op_sub,
  input logic [WIDTH-1:0] prod_hi,
  input logic [WIDTH-1:0] prod_lo
);

  int unsigned busy_cycles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              busy_cycles <= 0;
    else if (start && !busy) busy_cycles <= 0;
    else if (busy)           busy_cycles <= busy_cycles + 1;
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R3
  iter_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_cycles == WIDTH) && !busy);

  // R7
  no_early_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(prod_hi) && $stable(prod_lo)));

  // R4
  recode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_add, op_sub}));

endmodule

bind booth_seq_mult booth_seq_mult_chk #(.WIDTH(WIDTH)) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .op_add (op_add),
  .op_sub (op_sub),
  .prod_hi(prod_hi),
  .prod_lo(prod_lo)
);

// File: tb/booth_seq_mult_tb_top.sv
`timescale 1ns/1ps
module booth_seq_mult_tb_top;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] mcand = '0;
  logic [W-1:0] mplier = '0;
  logic         busy, done;
  logic [W-1:0] prod_hi, prod_lo;

  logic         start4 = 1'b0;
  logic [3:0]   mcand4 = '0;
  logic [3:0]   mplier4 = '0;
  logic         busy4, done4;
  logic [3:0]   hi4, lo4;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  logic [2*W-1:0] exp_q[$];
  int             due_q[$];
  logic [2*W-1:0] last_exp = '0;

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  booth_seq_mult #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand_i(mcand), .mplier_i(mplier),
    .busy(busy), .done(done), .prod_hi(prod_hi), .prod_lo(prod_lo)
  );

  booth_seq_mult #(.WIDTH(4)) dut4_i (
    .clk(clk), .rst_n(rst_n), .start(start4), .mcand_i(mcand4), .mplier_i(mplier4),
    .busy(busy4), .done(done4), .prod_hi(hi4), .prod_lo(lo4)
  );

  function automatic logic [2*W-1:0] ref_prod(input logic [W-1:0] a, input logic [W-1:0] b);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    return 64'(sa * sb);
  endfunction

  task automatic check(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: wait until idle, issue, queue the expected product and its due cycle
  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    while (busy) @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);            // the accepting edge has passed; cyc holds its count
    start = 1'b0;
    exp_q.push_back(ref_prod(a, b));
    due_q.push_back(cyc + W);
  endtask

  // R7: a stray start with other operands while busy
  task automatic poke_while_busy(input logic [W-1:0] a, input logic [W-1:0] b);
    repeat (5) @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while (exp_q.size() != 0 && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R7: unexpected done, actual=1 expected=0");
      end else begin
        logic [2*W-1:0] e;
        int d;
        e = exp_q.pop_front();
        d = due_q.pop_front();
        check("R3 done cycle", 64'(cyc), 64'(d));
        check("R4 R9 product", {prod_hi, prod_lo}, e);
        last_exp = e;
      end
    end
  end

  task automatic run4(input logic [3:0] a, input logic [3:0] b, input logic [7:0] exp);
    int guard = 0;
    @(negedge clk);
    while (busy4) @(negedge clk);
    mcand4 = a; mplier4 = b; start4 = 1'b1;
    @(negedge clk);
    start4 = 1'b0;
    while (!done4 && guard < 20) begin @(negedge clk); guard++; end
    check("R5 4-bit product", 64'({hi4, lo4}), 64'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] lf;
    repeat (3) @(negedge clk);
    // R1
    check("R1 reset state", {62'(0), busy, done}, 64'(0));
    check("R1 reset product", {prod_hi, prod_lo}, 64'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // R5
    run4(4'd2, 4'd7, 8'b0000_1110);
    run4(4'd2, 4'b1101, 8'b1111_1010);

    // R4 plain patterns, back to back
    issue(32'd3, 32'd5);
    issue(-32'sd7, 32'd2);
    issue(32'd2, -32'sd3);
    issue(-32'sd1, -32'sd1);
    issue(32'd0, -32'sd5);
    issue(32'h7fffffff, 32'h7fffffff);
    issue(32'h55555555, 32'haaaaaaaa);
    issue(32'h12345678, 32'hf1234568);
    // R6 extremes
    issue(32'h80000000, 32'h80000000);
    issue(32'h80000000, 32'hffffffff);
    issue(32'h80000000, 32'h00000001);
    issue(32'h7fffffff, 32'h80000000);
    // R7
    issue(32'd1234, -32'sd99);
    poke_while_busy(32'hdeadbeef, 32'h0badf00d);
    drain();
    // R8: done low, result held
    repeat (3) @(negedge clk);
    check("R8 done pulse", 64'(done), 64'(0));
    check("R8 result held", {prod_hi, prod_lo}, last_exp);
    // R4 pseudo-random
    lf = 32'hace1_2468;
    for (int i = 0; i < 8; i++) begin
      logic [W-1:0] a;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      a = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      issue(a, lf ^ 32'h9e37_79b9);
    end
    drain();
    check("R7 queue empty", 64'(exp_q.size()), 64'(0));

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule